// File: doc/BRIEF.md
# Selectable PRBS Receive Checker

This block watches a stream of raw parallel receive words and judges whether they follow one of four standard pseudo-random binary sequences. The words are taken straight from the deserializer, before any comma alignment or line decoding. A select input picks the sequence or turns checking off. A polarity control can invert every received bit before it reaches the checker, which covers a swapped differential pair.

The checker needs no seed from outside. It keeps the most recent 31 received bits as its history. It predicts every new bit from that history using the feedback taps of the selected polynomial, and any bit that differs from its prediction is a mismatch. The history is always built from the bits actually received, so the checker locks onto a clean stream at any phase. A single flipped line bit shows up as one mismatch for the bit itself, plus one more for each tap that later reads it.

The data input is a stream with a valid qualifier only. The checker takes a word on every clock edge where `in_valid` is high and never applies back-pressure, so there is no ready signal. Both outputs are registered and update on the clock edge that takes the word.

Top module: `prbs_rx_checker`

## Requirements
- R1: `pat_sel` picks the sequence: 1 = x^7+x^6+1, 2 = x^15+x^14+1, 3 = x^23+x^18+1, 4 = x^31+x^28+1. The values 0, 5, 6 and 7 disable checking.
- R2: `in_data[0]` is the earliest bit of a word, and bit k of the stream satisfies s[k] = s[k-N] ^ s[k-M] for the taps N and M given in R1. A clean stream at any starting phase produces no mismatches once seeding is complete.
- R3: When `rx_invert` is 1, every received bit is inverted before it is checked and before it enters the history. When `rx_invert` is 0, the bits pass through unchanged.
- R4: `err_flag` is high for the cycle after a checked word that has at least one mismatched bit, and low after every other edge.
- R5: `err_count` adds the number of mismatched bits in each checked word. It saturates at 0xFFFF and never wraps.
- R6: On any edge where `pat_sel` differs from its value at the previous edge, `err_count` is cleared to 0, `err_flag` goes low and seeding restarts.
- R7: While checking is disabled, `err_flag` stays low and `err_count` is frozen.
- R8: The first valid word after a reset or a change of `pat_sel` only seeds the history. That word is never flagged or counted.
- R9: During and directly after reset, `err_flag` is 0 and `err_count` is 0.
- R10: On an edge with `in_valid` low, `in_data` is ignored. The history is left unchanged, so a clean stream with idle gaps still checks clean. `err_flag` goes low and `err_count` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_data` as a received word. Always accepted. |
| in_data | input | DATA_W | Raw parallel receive word; bit 0 is the earliest bit |
| pat_sel | input | 3 | Sequence select; see R1 |
| rx_invert | input | 1 | Inverts the received bits before checking |
| err_flag | output | 1 | The last checked word had a mismatch |
| err_count | output | CNT_W | Saturating count of mismatched bits |

## Verification
The bench drives clean sequences of every polynomial, each from a random starting phase. It separates a design that uses the wrong taps or bit order, which would flag clean data, from one that compares the seed word, which would raise a spurious flag right after every select change. It injects isolated bit errors so that the count must show the self-synchronising tripling; a checker that tracked a free-running register would count one error per flip or lose lock. It also drives idle gaps filled with junk, a run of junk long enough to reach the 0xFFFF ceiling, and a mid-stream polarity flip. A design that let idle data into the history, wrapped its counter, or inverted after the history would show errors or counts that differ from the bench model.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  localparam int HIST_W  = 31;
  localparam int NUM_PAT = 4;

  typedef enum logic [2:0] {
    SEL_OFF = 3'd0,
    SEL_P7  = 3'd1,
    SEL_P15 = 3'd2,
    SEL_P23 = 3'd3,
    SEL_P31 = 3'd4
  } pat_sel_e;

  // Long feedback lag for pattern index 0..3
  function automatic int lag_long(input int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  // Short feedback lag for pattern index 0..3
  function automatic int lag_short(input int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

  function automatic logic pat_is_active(input logic [2:0] sel);
    return (sel >= SEL_P7) && (sel <= SEL_P31);
  endfunction
endpackage

// File: rtl/prbs_chk_front.sv
module prbs_chk_front #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              invert_i,
  output logic [DATA_W-1:0] word_o
);
  // Polarity correction ahead of the history and the comparison (R3)
  assign word_o = raw_i ^ {DATA_W{invert_i}};
endmodule

// File: rtl/prbs_chk_predict.sv
module prbs_chk_predict
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [HIST_W-1:0] hist_i,    // [HIST_W-1] is the newest bit
  input  logic [1:0]        pat_idx_i,
  output logic [DATA_W-1:0] miss_o,
  output logic [HIST_W-1:0] hist_o
);
  localparam int EXT_W = DATA_W + HIST_W;

  logic [EXT_W-1:0] ext;
  logic [NUM_PAT-1:0][DATA_W-1:0] miss_pat;

  // History followed by the new word, oldest bit at index 0
  assign ext = {word_i, hist_i};

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    localparam int LN = lag_long(g);
    localparam int LS = lag_short(g);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      // Prediction uses received bits only, which makes the check self-synchronising (R2)
      assign miss_pat[g][i] = ext[HIST_W+i] ^ ext[HIST_W+i-LN] ^ ext[HIST_W+i-LS];
    end
  end

  assign miss_o = miss_pat[pat_idx_i];
  assign hist_o = ext[EXT_W-1 -: HIST_W];
endmodule

// File: rtl/prbs_chk_popcount.sv
module prbs_chk_popcount #(
  parameter int IN_W  = 32,
  parameter int OUT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  bits_i,
  output logic [OUT_W-1:0] ones_o
);
  always_comb begin
    ones_o = '0;
    for (int i = 0; i < IN_W; i++) begin
      ones_o = ones_o + OUT_W'(bits_i[i]);
    end
  end
endmodule

// File: rtl/prbs_chk_sat_counter.sv
module prbs_chk_sat_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0] sum;

  assign sum = {1'b0, count_o} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      count_o <= '0;
    end else if (inc_en_i) begin
      count_o <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end
  end

  // R5: once full, the count stays full until cleared
  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && !clr_i) |=> (count_o == CNT_MAX));

  // R5: without a clear the count never moves down
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (count_o >= $past(count_o)));
endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [2:0]        pat_sel,
  input  logic              rx_invert,
  output logic              err_flag,
  output logic [CNT_W-1:0]  err_count
);
  localparam int POP_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] miss;
  logic [POP_W-1:0]  miss_cnt;
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;
  logic [2:0]        pat_q;
  logic              seeded_q;
  logic              sel_change;
  logic              sel_on;
  logic [1:0]        pat_idx;
  logic              do_check;

  assign sel_change = (pat_sel != pat_q);
  assign sel_on     = pat_is_active(pat_sel);
  assign pat_idx    = 2'(pat_sel - 3'd1);
  assign do_check   = in_valid && sel_on && seeded_q && !sel_change;

  prbs_chk_front #(.DATA_W(DATA_W)) u_front (
    .raw_i    (in_data),
    .invert_i (rx_invert),
    .word_o   (rx_word)
  );

  prbs_chk_predict #(.DATA_W(DATA_W)) u_pred (
    .word_i    (rx_word),
    .hist_i    (hist_q),
    .pat_idx_i (pat_idx),
    .miss_o    (miss),
    .hist_o    (hist_nxt)
  );

  prbs_chk_popcount #(.IN_W(DATA_W), .OUT_W(POP_W)) u_pop (
    .bits_i (miss),
    .ones_o (miss_cnt)
  );

  prbs_chk_sat_counter #(.CNT_W(CNT_W), .INC_W(POP_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (sel_change),
    .inc_en_i (do_check),
    .inc_i    (miss_cnt),
    .count_o  (err_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q    <= SEL_OFF;
      seeded_q <= 1'b0;
      hist_q   <= '0;
      err_flag <= 1'b0;
    end else begin
      pat_q <= pat_sel;
      if (in_valid) hist_q <= hist_nxt;          // R10: idle words never enter the history
      if (sel_change)              seeded_q <= in_valid && sel_on;  // R8
      else if (in_valid && sel_on) seeded_q <= 1'b1;
      err_flag <= do_check && (|miss);           // R4
    end
  end

  // R6: a select change clears both outputs
  assert_change_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (err_count == '0 && !err_flag));

  // R7: disabled checking leaves the outputs quiet
  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_change && !sel_on) |=> (!err_flag && $stable(err_count)));

  // R8: a seeding word is never flagged
  assert_seed_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_change || !seeded_q) |=> !err_flag);

  // R10: an idle edge holds the count and drops the flag
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !sel_change) |=> (!err_flag && $stable(err_count)));

  // R4: a raised flag goes with a counted mismatch
  assert_flag_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (err_count > $past(err_count) || err_count == CNT_MAX));
endmodule

// File: tb/prbs_rx_checker_tb.sv
module prbs_rx_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int CW = 16;
  localparam int MAXC = 65535;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [2:0]    pat_sel = 3'd0;
  logic          rx_invert = 1'b0;
  logic          err_flag;
  logic [CW-1:0] err_count;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R9";

  // Bench model state
  logic [30:0] gh;          // generator history, [0] newest
  logic [30:0] rh;          // receive history, [0] newest
  logic [2:0]  msel = 3'd0;
  int          mcnt = 0;
  logic        mflag = 1'b0;
  logic        mseeded = 1'b0;

  prbs_rx_checker #(.DATA_W(W), .CNT_W(CW)) u_dut (
    .clk, .rst_n, .in_valid, .in_data, .pat_sel, .rx_invert, .err_flag, .err_count
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lag_n(input logic [2:0] s);
    case (s) 3'd1: return 7; 3'd2: return 15; 3'd3: return 23; default: return 31; endcase
  endfunction
  function automatic int lag_m(input logic [2:0] s);
    case (s) 3'd1: return 6; 3'd2: return 14; 3'd3: return 18; default: return 28; endcase
  endfunction
  function automatic logic active(input logic [2:0] s);
    return s >= 3'd1 && s <= 3'd4;
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input logic [CW-1:0] got_c, input logic got_f);
    checks++;
    if (got_f !== mflag) begin
      fails++;
      $display("FAIL %s err_flag: actual %0b expected %0b", cur_tag, got_f, mflag);
    end
    checks++;
    if (got_c !== CW'(mcnt)) begin
      fails++;
      $display("FAIL %s err_count: actual %0d expected %0d", cur_tag, got_c, mcnt);
    end
  endtask

  task automatic reseed_gen;
    gh = 31'($urandom());
    gh[0] = 1'b1;
  endtask

  // Next clean word of the stream s[k] = s[k-N] ^ s[k-M], bit 0 first (R2)
  task automatic clean_word(input logic [2:0] s, output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      logic b;
      b = gh[lag_n(s)-1] ^ gh[lag_m(s)-1];
      gh = {gh[29:0], b};
      w[i] = b;
    end
  endtask

  // One edge: drive, update the model, then sample after the edge
  task automatic step(input logic v, input logic [W-1:0] w, input logic [2:0] s, input logic inv);
    logic [W-1:0] eff;
    logic chg;
    int mism;
    @(negedge clk);
    in_valid = v; in_data = w; pat_sel = s; rx_invert = inv;
    eff = inv ? ~w : w;
    chg = (s != msel);
    mism = 0;
    if (chg) begin
      msel = s; mcnt = 0; mseeded = 1'b0;
    end
    if (v) begin
      for (int i = 0; i < W; i++) begin
        logic e;
        e = rh[lag_n(s)-1] ^ rh[lag_m(s)-1];
        if (e != eff[i]) mism++;
        rh = {rh[29:0], eff[i]};
      end
    end
    mflag = 1'b0;
    if (chg) begin
      mseeded = v && active(s);
    end else if (v && active(s)) begin
      if (mseeded) begin
        mflag = (mism > 0);
        mcnt = (mcnt + mism > MAXC) ? MAXC : mcnt + mism;
      end
      mseeded = 1'b1;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(err_count, err_flag);
  endtask

  task automatic clean_run(input int n, input logic [2:0] s, input logic inv);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] w;
      clean_word(s, w);
      step(1'b1, inv ? ~w : w, s, inv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rh = '0;

    // R9: reset state
    cur_tag = "R9";
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(err_count, err_flag);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check(err_count, err_flag);

    // R1 R2 R8: each polynomial, random phase, first word only seeds
    for (int s = 1; s <= 4; s++) begin
      reseed_gen();
      cur_tag = "R8";
      clean_run(1, 3'(s), 1'b0);
      cur_tag = "R1";
      clean_run(20, 3'(s), 1'b0);
    end

    // R3: inverted line with inversion on is clean; inversion off is not
    cur_tag = "R3";
    clean_run(10, 3'd4, 1'b1);
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] w;
      clean_word(3'd4, w);
      step(1'b1, ~w, 3'd4, 1'b0);
    end

    // R6: change clears, then R4 R5 R10 with errors and idle junk
    cur_tag = "R6";
    reseed_gen();
    clean_run(3, 3'd2, 1'b0);
    cur_tag = "R4";
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 4) == 0) begin
        cur_tag = "R10";
        step(1'b0, W'($urandom()), 3'd2, 1'b0);
      end else begin
        logic [W-1:0] w;
        cur_tag = "R4";
        clean_word(3'd2, w);
        if ($urandom_range(0, 3) == 0) w[$urandom_range(0, W-1)] ^= 1'b1;
        step(1'b1, w, 3'd2, 1'b0);
      end
    end

    // R7: disabled selects keep the outputs quiet
    cur_tag = "R7";
    for (int k = 0; k < 10; k++) step(1'b1, W'($urandom()), 3'd0, 1'b0);
    for (int k = 0; k < 10; k++) step(1'b1, W'($urandom()), 3'd6, 1'b0);

    // R5: junk until the count saturates, then keep going
    cur_tag = "R5";
    for (int k = 0; k < 4800; k++) step(1'b1, W'($urandom()), 3'd4, 1'b0);

    // R6: change after saturation clears
    cur_tag = "R6";
    reseed_gen();
    clean_run(15, 3'd3, 1'b0);

    // R2: random mix of selects, gaps, errors and polarity
    cur_tag = "R2";
    begin
      logic [2:0] s;
      logic inv;
      s = 3'd3; inv = 1'b0;
      for (int k = 0; k < 800; k++) begin
        logic [W-1:0] w;
        if ($urandom_range(0, 60) == 0) begin
          s = 3'($urandom_range(0, 7));
          if (active(s)) reseed_gen();
        end
        if ($urandom_range(0, 80) == 0) inv = ~inv;
        if ($urandom_range(0, 5) == 0) begin
          step(1'b0, W'($urandom()), s, inv);
        end else begin
          clean_word(active(s) ? s : 3'd4, w);
          if ($urandom_range(0, 7) == 0) w[$urandom_range(0, W-1)] ^= 1'b1;
          step(1'b1, inv ? ~w : w, s, inv);
        end
      end
    end

    report();
    $finish;
  end
endmodule